// File: doc/BRIEF.md
# Time-Sync Capture and Interrupt Cause Unit

This unit records the running precision-time value (a seconds count and a nanoseconds count supplied by a neighbouring clock block) whenever one of three things happens. A rising edge can arrive on either of two asynchronous auxiliary inputs, or a transmit-start strobe can mark the moment a timestamped frame leaves. Each captured value is kept as a nanoseconds word and a seconds word that software reads through a small register port.

The same unit gathers the time-sync event sources into an eight-bit cause register. A mask register with the same layout selects which causes drive the single interrupt line. Software acknowledges a cause by writing a one to its bit. The auxiliary captures are armed by per-channel enable bits. The transmit capture has one slot: while its valid flag is up, no new frame can be stamped. Reading a seconds word releases the slot it belongs to.

Register access is a plain single-cycle strobe interface with registered read data and no stalls. The time inputs and event pulses are level or pulse signals from neighbouring logic, so no valid/ready handshake and no back-pressure exists anywhere on the block.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset the cause, mask and capture-enable registers are zero, both transmit and auxiliary slots are empty, `irq` is low and `reg_rdata` is zero.
- R2: A one-cycle pulse on an event input sets its cause bit (address 0) on the next clock edge. The bit positions are: 0 second wrap, 1 transmit capture, 2 receive stamp, 3 target 0, 4 target 1, 5 auxiliary 0 capture, 6 auxiliary 1 capture, 7 adjust done.
- R3: `irq` is high exactly when some cause bit is set whose bit in the mask register (address 1, bits 7:0) is also set.
- R4: A write to address 0 clears each cause bit written as one and leaves each bit written as zero unchanged.
- R5: When a cause bit is set by an event and cleared by a write in the same cycle, it remains set.
- R6: With enable bit i of address 9 set, a rising edge on `aux_pin[i]` is sampled through a two-flop synchronizer. If the pin is sampled high at clock edge k after being low, the time present at edge k+2 is stored: nanoseconds at address 5+2i, seconds at address 6+2i. Cause bit 5+i is set at the same edge.
- R7: After an auxiliary capture, later edges on that pin store nothing and set no cause until the seconds word of that channel is read. The read re-arms the channel.
- R8: Edges on an auxiliary pin whose enable bit is clear store nothing and set no cause.
- R9: A `tx_start` pulse while the transmit slot is empty stores the current time (nanoseconds at address 3, seconds at address 4). It also sets the valid flag (bit 0 of address 2) and cause bit 1.
- R10: While the valid flag is set, `tx_start` pulses change neither the stored time nor the cause register. Reading address 4 clears the flag.
- R11: `reg_rdata` updates only on a read strobe, one cycle later, with the register value before that edge's updates. Unmapped addresses read zero, and writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ns | input | NS_W | Current nanoseconds of the time base |
| cur_sec | input | SEC_W | Current seconds of the time base |
| aux_pin | input | 2 | Asynchronous auxiliary capture inputs |
| tx_start | input | 1 | Transmit-start strobe of a frame to stamp |
| ev_wrap | input | 1 | Second-wrap event pulse |
| ev_rx | input | 1 | Receive-stamp event pulse |
| ev_target | input | 2 | Target-time reached pulses, channels 0 and 1 |
| ev_adj | input | 1 | Time-adjust-done pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench drives single event pulses one source at a time, so a wrong bit position shows up as a wrong cause value. It also drives an acknowledge that lands in the same cycle as a new event, which separates set-priority from clear-priority. Auxiliary pins are toggled with the enable off, then on, then again while a capture is held. This distinguishes a missing synchronizer or edge detector, a missing hold, and a lost re-arm. Transmit strobes are repeated while the slot is full and again after the seconds word is read, which exposes overwrite and stale-flag faults. The time base keeps advancing throughout, so every stored value also shows the cycle at which it was taken.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int NUM_CAUSE = 8;
  localparam int NUM_AUX   = 2;
  localparam int ADR_W     = 4;

  localparam int C_WRAP = 0;
  localparam int C_TX   = 1;
  localparam int C_RX   = 2;
  localparam int C_TGT0 = 3;
  localparam int C_TGT1 = 4;
  localparam int C_AUX0 = 5;
  localparam int C_AUX1 = 6;
  localparam int C_ADJ  = 7;

  localparam logic [ADR_W-1:0] ADR_CAUSE    = 4'd0;
  localparam logic [ADR_W-1:0] ADR_MASK     = 4'd1;
  localparam logic [ADR_W-1:0] ADR_TXCTL    = 4'd2;
  localparam logic [ADR_W-1:0] ADR_TX_NS    = 4'd3;
  localparam logic [ADR_W-1:0] ADR_TX_SEC   = 4'd4;
  localparam logic [ADR_W-1:0] ADR_AUX_BASE = 4'd5;
  localparam logic [ADR_W-1:0] ADR_CAPCTL   = 4'd9;
endpackage

// File: rtl/ts_edge_capture.sv
module ts_edge_capture #(
  parameter int NS_W        = 30,
  parameter int SEC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             enable,
  input  logic             rearm,
  input  logic [NS_W-1:0]  cur_ns,
  input  logic [SEC_W-1:0] cur_sec,
  output logic             cap_pulse,
  output logic [NS_W-1:0]  cap_ns,
  output logic [SEC_W-1:0] cap_sec
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   held_q;
  logic                   rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise      = sync_q[LAST] & ~prev_q;
  assign cap_pulse = rise & enable & ~held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      cap_ns  <= '0;
      cap_sec <= '0;
    end else if (cap_pulse) begin
      held_q  <= 1'b1;
      cap_ns  <= cur_ns;
      cap_sec <= cur_sec;
    end else if (rearm) begin
      held_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_tx_capture.sv
module ts_tx_capture #(
  parameter int NS_W  = 30,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             rd_high,
  input  logic [NS_W-1:0]  cur_ns,
  input  logic [SEC_W-1:0] cur_sec,
  output logic             cap_pulse,
  output logic             valid,
  output logic [NS_W-1:0]  cap_ns,
  output logic [SEC_W-1:0] cap_sec
);
  assign cap_pulse = tx_start & ~valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      cap_ns  <= '0;
      cap_sec <= '0;
    end else if (cap_pulse) begin
      valid   <= 1'b1;
      cap_ns  <= cur_ns;
      cap_sec <= cur_sec;
    end else if (rd_high) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_cause_reg.sv
module ts_cause_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] cause_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq = |(cause_q & mask_q);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter int NS_W        = 30,
  parameter int SEC_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS_W-1:0]   cur_ns,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [1:0]        aux_pin,
  input  logic              tx_start,
  input  logic              ev_wrap,
  input  logic              ev_rx,
  input  logic [1:0]        ev_target,
  input  logic              ev_adj,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_CAUSE-1:0] set_vec, clr_vec, cause_q, mask_q;
  logic [NUM_AUX-1:0]   capctl_q;
  logic [NUM_AUX-1:0]   aux_cap;
  logic [NS_W-1:0]      aux_ns  [NUM_AUX];
  logic [SEC_W-1:0]     aux_sec [NUM_AUX];
  logic                 tx_cap, tx_valid, tx_rd_high;
  logic [NS_W-1:0]      tx_ns;
  logic [SEC_W-1:0]     tx_sec;
  logic [DATA_W-1:0]    tx_sec_w;
  logic [DATA_W-1:0]    rd_mux;
  logic                 wr_cause;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_CAUSE];
  assign wr_cause     = reg_wr && (reg_addr == ADR_CAUSE);
  assign clr_vec      = wr_cause ? reg_wdata[NUM_CAUSE-1:0] : '0;
  assign tx_rd_high   = reg_rd && (reg_addr == ADR_TX_SEC);
  assign tx_sec_w     = DATA_W'(tx_sec);

  always_ff @(posedge clk) begin
    if (!rst_n)                                capctl_q <= '0;
    else if (reg_wr && reg_addr == ADR_CAPCTL) capctl_q <= reg_wdata[NUM_AUX-1:0];
  end

  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
    localparam logic [ADR_W-1:0] SEC_ADR = ADR_W'(ADR_AUX_BASE + 2*i + 1);
    ts_edge_capture #(
      .NS_W(NS_W), .SEC_W(SEC_W), .SYNC_STAGES(SYNC_STAGES)
    ) i_aux (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (aux_pin[i]),
      .enable    (capctl_q[i]),
      .rearm     (reg_rd && (reg_addr == SEC_ADR)),
      .cur_ns    (cur_ns),
      .cur_sec   (cur_sec),
      .cap_pulse (aux_cap[i]),
      .cap_ns    (aux_ns[i]),
      .cap_sec   (aux_sec[i])
    );
  end

  ts_tx_capture #(.NS_W(NS_W), .SEC_W(SEC_W)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .rd_high   (tx_rd_high),
    .cur_ns    (cur_ns),
    .cur_sec   (cur_sec),
    .cap_pulse (tx_cap),
    .valid     (tx_valid),
    .cap_ns    (tx_ns),
    .cap_sec   (tx_sec)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[C_WRAP] = ev_wrap;
    set_vec[C_TX]   = tx_cap;
    set_vec[C_RX]   = ev_rx;
    set_vec[C_TGT0] = ev_target[0];
    set_vec[C_TGT1] = ev_target[1];
    set_vec[C_ADJ]  = ev_adj;
    for (int i = 0; i < NUM_AUX; i++) set_vec[C_AUX0+i] = aux_cap[i];
  end

  ts_cause_reg #(.N(NUM_CAUSE)) i_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .mask_we    (reg_wr && (reg_addr == ADR_MASK)),
    .mask_wdata (reg_wdata[NUM_CAUSE-1:0]),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .irq        (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_CAUSE:  rd_mux = DATA_W'(cause_q);
      ADR_MASK:   rd_mux = DATA_W'(mask_q);
      ADR_TXCTL:  rd_mux = DATA_W'(tx_valid);
      ADR_TX_NS:  rd_mux = DATA_W'(tx_ns);
      ADR_TX_SEC: rd_mux = tx_sec_w;
      ADR_CAPCTL: rd_mux = DATA_W'(capctl_q);
      default:    rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_AUX; i++) begin
      if (reg_addr == ADR_W'(ADR_AUX_BASE + 2*i))     rd_mux = DATA_W'(aux_ns[i]);
      if (reg_addr == ADR_W'(ADR_AUX_BASE + 2*i + 1)) rd_mux = DATA_W'(aux_sec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ts_capture_unit_chk.sv
module ts_capture_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        set_vec,
  input logic [7:0]        cause_q,
  input logic              irq,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [1:0]        aux_cap,
  input logic              tx_cap,
  input logic              tx_valid,
  input logic              tx_rd_high,
  input logic [DATA_W-1:0] tx_sec_w
);
  // R2
  wrap_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> cause_q[0]);

  // R6
  aux0_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_cap[0] |=> cause_q[5]);

  // R9
  tx_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cap |=> (tx_valid && cause_q[1]));

  // R10
  tx_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_rd_high) |=> (tx_valid && $stable(tx_sec_w)));

  // R4
  full_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && reg_wdata[7:0] == 8'hFF && set_vec == 8'h00) |=> !irq);

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[2] && reg_wr && reg_addr == 4'd0 && reg_wdata[2]) |=> cause_q[2]);
endmodule

bind ts_capture_unit ts_capture_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_vec    (set_vec),
  .cause_q    (cause_q),
  .irq        (irq),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .aux_cap    (aux_cap),
  .tx_cap     (tx_cap),
  .tx_valid   (tx_valid),
  .tx_rd_high (tx_rd_high),
  .tx_sec_w   (tx_sec_w)
);

// File: tb/test_ts_capture_unit.sv
module test_ts_capture_unit;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [29:0] cur_ns = 30'd999_999_000;
  logic [31:0] cur_sec = 32'd5;
  logic [1:0]  aux_pin = 0;
  logic        tx_start = 0, ev_wrap = 0, ev_rx = 0, ev_adj = 0;
  logic [1:0]  ev_target = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit started = 0, done = 0;

  ts_capture_unit i_ts_capture_unit (
    .clk(clk), .rst_n(rst_n), .cur_ns(cur_ns), .cur_sec(cur_sec),
    .aux_pin(aux_pin), .tx_start(tx_start), .ev_wrap(ev_wrap), .ev_rx(ev_rx),
    .ev_target(ev_target), .ev_adj(ev_adj), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  logic [7:0]  m_cause, m_mask;
  logic [1:0]  m_capctl, m_held;
  logic        m_txv;
  logic [29:0] m_tx_ns;
  logic [31:0] m_tx_sec, m_rdata;
  logic [29:0] m_aux_ns [2];
  logic [31:0] m_aux_sec [2];
  logic [2:0]  m_pin_hist [2];
  logic [3:0]  m_last_addr;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      0: return {24'd0, m_cause};
      1: return {24'd0, m_mask};
      2: return {31'd0, m_txv};
      3: return {2'd0, m_tx_ns};
      4: return m_tx_sec;
      5: return {2'd0, m_aux_ns[0]};
      6: return m_aux_sec[0];
      7: return {2'd0, m_aux_ns[1]};
      8: return m_aux_sec[1];
      9: return {30'd0, m_capctl};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = 0; m_mask = 0; m_capctl = 0; m_held = 0; m_txv = 0;
      m_tx_ns = 0; m_tx_sec = 0; m_rdata = 0; m_last_addr = 0;
      for (int i = 0; i < 2; i++) begin
        m_aux_ns[i] = 0; m_aux_sec[i] = 0; m_pin_hist[i] = 0;
      end
    end else begin
      logic [7:0] setv, clr;
      setv = 0;
      if (reg_rd) begin
        m_rdata = m_read(reg_addr);
        m_last_addr = reg_addr;
      end
      for (int i = 0; i < 2; i++) begin
        // hist[1] = pin as seen two edges ago, hist[2] = three edges ago
        bit cap;
        cap = m_pin_hist[i][1] && !m_pin_hist[i][2] && m_capctl[i] && !m_held[i];
        m_pin_hist[i] = {m_pin_hist[i][1:0], aux_pin[i]};
        if (cap) begin
          m_aux_ns[i] = cur_ns; m_aux_sec[i] = cur_sec; m_held[i] = 1;
        end else if (reg_rd && reg_addr == 4'(6 + 2*i)) m_held[i] = 0;
        setv[5+i] = cap;
      end
      if (tx_start && !m_txv) begin
        m_tx_ns = cur_ns; m_tx_sec = cur_sec; m_txv = 1; setv[1] = 1;
      end else if (reg_rd && reg_addr == 4) m_txv = 0;
      setv[0] = ev_wrap; setv[2] = ev_rx; setv[3] = ev_target[0];
      setv[4] = ev_target[1]; setv[7] = ev_adj;
      clr = (reg_wr && reg_addr == 0) ? reg_wdata[7:0] : 8'h00;
      m_cause = (m_cause & ~clr) | setv;
      if (reg_wr && reg_addr == 1) m_mask = reg_wdata[7:0];
      if (reg_wr && reg_addr == 9) m_capctl = reg_wdata[1:0];
    end
  end

  function automatic string tag_of(input logic [3:0] a);
    if (a <= 1) return "R4";
    if (a <= 4) return "R10";
    if (a <= 8) return "R6";
    if (a == 9) return "R8";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      check("R3 irq", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
      check({tag_of(m_last_addr), " rdata"}, reg_rdata, m_rdata);
    end
  end

  // free-running time base
  initial forever begin
    @(negedge clk);
    if (cur_ns + 30'd8 >= 30'd1_000_000_000) begin
      cur_ns = cur_ns + 30'd8 - 30'd1_000_000_000;
      cur_sec = cur_sec + 1;
    end else cur_ns = cur_ns + 30'd8;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d, v1;
    wait_cyc(3);
    rst_n = 1;
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 0);
    check("R1 rdata after reset", reg_rdata, 0);
    started = 1;
    rd(0, d); check("R1 cause", d, 0);
    rd(1, d); check("R1 mask", d, 0);
    rd(2, d); check("R1 tx valid", d, 0);
    rd(9, d); check("R1 capctl", d, 0);

    // R2 / R3 / R4
    ev_wrap = 1; wait_cyc(1); ev_wrap = 0;
    rd(0, d); check("R2 wrap bit 0", d, 32'h01);
    check("R3 masked off", {31'd0, irq}, 0);
    wr(1, 32'hFF);
    check("R3 unmasked", {31'd0, irq}, 1);
    wr(0, 32'h02);
    rd(0, d); check("R4 zero bits untouched", d, 32'h01);
    wr(0, 32'h01);
    rd(0, d); check("R4 ack clears", d, 0);
    check("R4 irq drops", {31'd0, irq}, 0);

    // R5 event wins over acknowledge
    ev_rx = 1; wait_cyc(1); ev_rx = 0;
    ev_rx = 1; wr(0, 32'h04); ev_rx = 0;
    rd(0, d); check("R5 set beats clear", d, 32'h04);
    wr(0, 32'hFF);

    // R2 remaining sources
    ev_target = 2'b01; wait_cyc(1); ev_target = 0;
    rd(0, d); check("R2 target0 bit 3", d, 32'h08);
    wr(0, 32'hFF);
    ev_target = 2'b10; wait_cyc(1); ev_target = 0;
    rd(0, d); check("R2 target1 bit 4", d, 32'h10);
    wr(0, 32'hFF);
    ev_adj = 1; wait_cyc(1); ev_adj = 0;
    rd(0, d); check("R2 adjust bit 7", d, 32'h80);
    wr(0, 32'hFF);

    // R8 disabled capture
    aux_pin[0] = 1; wait_cyc(5);
    rd(0, d); check("R8 no cause when disabled", d, 0);
    rd(5, d); check("R8 nothing stored", d, 0);
    aux_pin[0] = 0; wait_cyc(4);

    // R6 capture
    wr(9, 32'h3);
    aux_pin[0] = 1; wait_cyc(4);
    rd(0, d); check("R6 aux0 cause bit 5", d, 32'h20);
    rd(5, v1); check("R6 aux0 ns", v1, {2'd0, m_aux_ns[0]});
    check("R6 aux0 ns nonzero", {31'd0, v1 != 0}, 1);
    wr(0, 32'hFF);

    // R7 held until seconds read
    aux_pin[0] = 0; wait_cyc(4);
    aux_pin[0] = 1; wait_cyc(4);
    rd(0, d); check("R7 held: no cause", d, 0);
    rd(5, d); check("R7 held: value kept", d, v1);
    rd(6, d); check("R6 aux0 sec", d, m_aux_sec[0]);
    aux_pin[0] = 0; wait_cyc(4);
    aux_pin[0] = 1; wait_cyc(4);
    rd(0, d); check("R7 re-armed capture", d, 32'h20);
    rd(5, d); check("R7 new value differs", {31'd0, d != v1}, 1);
    wr(0, 32'hFF);

    // R6 channel 1
    aux_pin[1] = 1; wait_cyc(4);
    rd(0, d); check("R6 aux1 cause bit 6", d, 32'h40);
    rd(7, d); check("R6 aux1 ns", d, {2'd0, m_aux_ns[1]});
    wr(0, 32'hFF);

    // R9 / R10 transmit
    tx_start = 1; wait_cyc(1); tx_start = 0;
    rd(2, d); check("R9 valid set", d, 1);
    rd(0, d); check("R9 cause bit 1", d, 32'h02);
    rd(3, v1); check("R9 tx ns", v1, {2'd0, m_tx_ns});
    wr(0, 32'hFF);
    wait_cyc(3);
    tx_start = 1; wait_cyc(1); tx_start = 0;
    rd(3, d); check("R10 not overwritten", d, v1);
    rd(0, d); check("R10 no new cause", d, 0);
    rd(4, d); check("R9 tx sec", d, m_tx_sec);
    rd(2, d); check("R10 valid cleared by sec read", d, 0);
    tx_start = 1; wait_cyc(1); tx_start = 0;
    rd(3, d); check("R10 fresh capture", {31'd0, d != v1}, 1);
    wr(0, 32'hFF);

    // R11 register port
    wr(2, 32'h0); rd(2, d); check("R11 read-only write ignored", d, 1);
    rd(4'd15, d); check("R11 unmapped reads zero", d, 0);
    wait_cyc(2);
    check("R11 rdata holds without strobe", reg_rdata, 0);

    wait_cyc(2);
    finish_run();
  end
endmodule